// File: doc/BRIEF.md
# SCSI Controller Status and Interrupt Register Unit

This block is the byte-wide register front of a SCSI bus controller. It holds the 16-bit transfer counter with a separate write-side copy, the status byte, the interrupt-reason byte, the sequence-step byte and the interrupt line. Software writes the counter bytes, the target number, a configuration byte and command bytes. The bus phase engine and the DMA engine report their progress through single-cycle event pulses.

The block decodes the command bytes. A command byte with the top bit set marks a DMA command and copies the write-side counter into the live counter. A select command aimed at a target that is absent or out of range ends at once with a disconnect interrupt. A bus-reset command posts a reset reason, and a configuration bit can hold back its interrupt. A read of the interrupt-reason byte acknowledges the interrupt. The block also gives the effective transfer length, in which a counter of zero stands for 65536 bytes.

Top module: `scsi_stat_irq`

## Requirements
- R1: After reset the status (addr 4), interrupt-reason (addr 5), sequence-step (addr 6) and counter bytes (addr 0, 1) read 0 and `irq` is low. Address 0x0E reads the chip identification value 4.
- R2: `xfer_len` equals the live counter, or 65536 when the live counter is 0.
- R3: Writes to addr 0 (low byte) and addr 1 (high byte) change only the write-side copy. Reads of addr 0 and 1 return the live counter.
- R4: A write to the command address 3 with bit 7 set loads the live counter from the write-side copy. With bit 7 clear the live counter is left unchanged.
- R5: A write to addr 0 or addr 1 clears status bit 4 (terminal count).
- R6: A DMA-done event ORs 0x90 (interrupt, terminal count) into the status byte. It sets the reason to bus-service 0x10, the sequence step to 0 and the live counter to 0, and it raises `irq`.
- R7: A read of addr 5 returns the reason byte and leaves it unchanged. It clears status bits 7, 6 and 5, keeps the other status bits and drops `irq`.
- R8: A command-done event sets the status byte to 0x90 OR the 3-bit `bus_phase`. It sets the reason to 0x18 (function-complete 0x08 plus bus-service 0x10) and the sequence step to 4, and it raises `irq`.
- R9: A select command (low 7 bits 0x41 or 0x42) whose target number (addr 4, bits 2:0) is 7 or is not flagged in `tgt_present` has the same effect as a selection-timeout event. Either one sets the status byte to 0x80, the reason to disconnect 0x20 and the sequence step to 0, and raises `irq`. A select command to a present target changes nothing.
- R10: A bus-reset command (low 7 bits 0x03) sets the reason to 0x80. It raises `irq` only when bit 6 of configuration register 8 is 0.
- R11: Parity-error and gross-error events set status bits 5 and 6 without raising `irq`.
- R12: When an event lands in the same cycle as a read of addr 5, the event's settings win over the clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| tgt_present | input | 7 | One flag per target number 0..6 |
| bus_phase | input | 3 | Current bus phase from the phase engine |
| evt_dma_done | input | 1 | DMA transfer finished |
| evt_sel_timeout | input | 1 | Selection timed out |
| evt_cmd_done | input | 1 | Command phase finished |
| evt_parity_err | input | 1 | Parity error seen |
| evt_gross_err | input | 1 | Gross error seen |
| irq | output | 1 | Interrupt request |
| xfer_len | output | 17 | Effective transfer length |

## Verification
Each register write and each event takes effect at the next rising edge. Read data, `irq` and `xfer_len` are then visible in the following cycle. Read data is combinational, so a read returns its value in the same cycle as the strobe. The clearing caused by that read shows from the next cycle. The bench drives strobes on the falling edge and holds each one for exactly one rising edge. The scoreboard monitor compares its queued expectations one nanosecond before the next rising edge, which is after the strobe has settled and before any register updates.

// File: rtl/scsi_si_pkg.sv
package scsi_si_pkg;
   localparam int REG_AW = 6;
   typedef logic [7:0] byte_t;

   localparam logic [REG_AW-1:0] ADR_CMD  = 6'h03;
   localparam logic [REG_AW-1:0] ADR_STAT = 6'h04;
   localparam logic [REG_AW-1:0] ADR_TGT  = 6'h04;
   localparam logic [REG_AW-1:0] ADR_WHY  = 6'h05;
   localparam logic [REG_AW-1:0] ADR_STEP = 6'h06;
   localparam logic [REG_AW-1:0] ADR_CFG  = 6'h08;
   localparam logic [REG_AW-1:0] ADR_ID   = 6'h0E;

   localparam int ST_INT = 7;
   localparam int ST_GE  = 6;
   localparam int ST_PE  = 5;
   localparam int ST_TC  = 4;

   localparam byte_t WHY_FC  = 8'h08;
   localparam byte_t WHY_BS  = 8'h10;
   localparam byte_t WHY_DC  = 8'h20;
   localparam byte_t WHY_RST = 8'h80;

   localparam byte_t STEP_DONE = 8'h04;

   localparam logic [6:0] OPC_SEL_A  = 7'h41;
   localparam logic [6:0] OPC_SEL_B  = 7'h42;
   localparam logic [6:0] OPC_BUSRST = 7'h03;
endpackage

// File: rtl/scsi_si_counter.sv
module scsi_si_counter
   import scsi_si_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_AW-1:0]    wr_addr,
   input  byte_t                wr_data,
   input  logic                 load,
   input  logic                 clear,
   output logic [CNT_W-1:0]     live,
   output logic [CNT_W:0]       eff_len,
   output logic                 lane_hit
);
   localparam int LANES = CNT_W / 8;

   logic [CNT_W-1:0] shadow;

   if (CNT_W % 8 != 0 || LANES < 1) begin : g_bad_width
      $error("scsi_si_counter: CNT_W must be a nonzero multiple of 8");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      byte_t sh_q, lv_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            sh_q <= '0;
         else if (wr_en && wr_addr == REG_AW'(i))
            sh_q <= wr_data;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)
            lv_q <= '0;
         else if (clear)
            lv_q <= '0;
         else if (load)
            lv_q <= sh_q;
      end
      assign shadow[i*8 +: 8] = sh_q;
      assign live[i*8 +: 8]   = lv_q;
   end

   assign lane_hit = wr_en && (wr_addr < REG_AW'(LANES));
   assign eff_len  = (live == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, live};

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear) |=> live == $past(shadow));
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> live == '0);
endmodule

// File: rtl/scsi_si_cmd_dec.sv
module scsi_si_cmd_dec
   import scsi_si_pkg::*;
#(
   parameter int MAX_TGT = 7,
   parameter int TGT_W   = 3
) (
   input  logic                cmd_wr,
   input  byte_t               cmd_byte,
   input  logic [TGT_W-1:0]    tgt_id,
   input  logic [MAX_TGT-1:0]  tgt_present,
   output logic                dma_load,
   output logic                sel_fail,
   output logic                bus_rst
);
   localparam int NID = 2 ** TGT_W;

   if (MAX_TGT >= NID || MAX_TGT < 1) begin : g_bad_tgt
      $error("scsi_si_cmd_dec: MAX_TGT must leave one id for the host");
   end

   logic [NID-1:0] absent;
   for (genvar j = 0; j < NID; j++) begin : g_id
      if (j < MAX_TGT) begin : g_real
         assign absent[j] = !tgt_present[j];
      end else begin : g_host
         assign absent[j] = 1'b1;
      end
   end

   logic is_sel;
   assign is_sel   = (cmd_byte[6:0] == OPC_SEL_A) || (cmd_byte[6:0] == OPC_SEL_B);
   assign dma_load = cmd_wr && cmd_byte[7];
   assign sel_fail = cmd_wr && is_sel && absent[tgt_id];
   assign bus_rst  = cmd_wr && (cmd_byte[6:0] == OPC_BUSRST);
endmodule

// File: rtl/scsi_si_status.sv
module scsi_si_status
   import scsi_si_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dma_done,
   input  logic       cmd_done,
   input  logic [2:0] phase,
   input  logic       disc,
   input  logic       bus_rst,
   input  logic       rst_mask,
   input  logic       par_err,
   input  logic       gross_err,
   input  logic       why_rd,
   input  logic       tc_clr,
   output byte_t      status,
   output byte_t      why,
   output byte_t      step,
   output logic       irq
);
   byte_t n_status, n_why, n_step;
   logic  n_irq;

   always_comb begin
      n_status = status;
      n_why    = why;
      n_step   = step;
      n_irq    = irq;
      if (why_rd) begin
         n_status[ST_INT] = 1'b0;
         n_status[ST_GE]  = 1'b0;
         n_status[ST_PE]  = 1'b0;
         n_irq            = 1'b0;
      end
      if (tc_clr)    n_status[ST_TC] = 1'b0;
      if (par_err)   n_status[ST_PE] = 1'b1;
      if (gross_err) n_status[ST_GE] = 1'b1;
      if (bus_rst) begin
         n_why = WHY_RST;
         if (!rst_mask) n_irq = 1'b1;
      end
      if (disc) begin
         n_status = 8'h80;
         n_why    = WHY_DC;
         n_step   = '0;
         n_irq    = 1'b1;
      end
      if (cmd_done) begin
         n_status = {5'b10010, phase};
         n_why    = WHY_FC | WHY_BS;
         n_step   = STEP_DONE;
         n_irq    = 1'b1;
      end
      if (dma_done) begin
         n_status[ST_INT] = 1'b1;
         n_status[ST_TC]  = 1'b1;
         n_why            = WHY_BS;
         n_step           = '0;
         n_irq            = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         why    <= '0;
         step   <= '0;
         irq    <= 1'b0;
      end else begin
         status <= n_status;
         why    <= n_why;
         step   <= n_step;
         irq    <= n_irq;
      end
   end

   logic any_evt;
   assign any_evt = dma_done || cmd_done || disc || bus_rst || par_err || gross_err;

   p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (why_rd && !any_evt) |=> (!irq && status[7:5] == 3'b000 && why == $past(why)));
   p_dma_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done |=> (irq && status[ST_INT] && status[ST_TC] && why == WHY_BS && step == '0));
   p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && (par_err || gross_err) && !why_rd && !dma_done && !cmd_done && !disc && !bus_rst)
      |=> !irq);
   p_rst_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst && rst_mask && !irq && !dma_done && !cmd_done && !disc) |=> (!irq && why == WHY_RST));
   p_tc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_clr && !dma_done && !cmd_done) |=> !status[ST_TC]);
endmodule

// File: rtl/scsi_stat_irq.sv
module scsi_stat_irq
   import scsi_si_pkg::*;
#(
   parameter int   CNT_W        = 16,
   parameter int   MAX_TGT      = 7,
   parameter int   TGT_W        = 3,
   parameter int   RST_MASK_BIT = 6,
   parameter logic [7:0] CHIP_ID = 8'h04
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [5:0]         reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   input  logic [MAX_TGT-1:0] tgt_present,
   input  logic [2:0]         bus_phase,
   input  logic               evt_dma_done,
   input  logic               evt_sel_timeout,
   input  logic               evt_cmd_done,
   input  logic               evt_parity_err,
   input  logic               evt_gross_err,
   output logic               irq,
   output logic [CNT_W:0]     xfer_len
);
   localparam int LANES = CNT_W / 8;

   if (LANES > int'(ADR_CMD)) begin : g_bad_lanes
      $error("scsi_stat_irq: counter bytes would overlap the command address");
   end
   if (RST_MASK_BIT < 0 || RST_MASK_BIT > 7) begin : g_bad_mask
      $error("scsi_stat_irq: RST_MASK_BIT must name a bit of a byte");
   end
   if (TGT_W > 8) begin : g_bad_tgtw
      $error("scsi_stat_irq: TGT_W must fit a byte");
   end

   logic [TGT_W-1:0] tgt_q;
   logic             mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q  <= '0;
         mask_q <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == ADR_TGT) tgt_q  <= reg_wdata[TGT_W-1:0];
         if (reg_addr == ADR_CFG) mask_q <= reg_wdata[RST_MASK_BIT];
      end
   end

   logic cmd_wr, dma_load, sel_fail, bus_rst, lane_hit, why_rd;
   logic [CNT_W-1:0] live;
   byte_t status, why, step;

   assign cmd_wr = reg_wr && reg_addr == ADR_CMD;
   assign why_rd = reg_rd && reg_addr == ADR_WHY;

   scsi_si_cmd_dec #(.MAX_TGT(MAX_TGT), .TGT_W(TGT_W)) u_dec (
      .cmd_wr      (cmd_wr),
      .cmd_byte    (reg_wdata),
      .tgt_id      (tgt_q),
      .tgt_present (tgt_present),
      .dma_load    (dma_load),
      .sel_fail    (sel_fail),
      .bus_rst     (bus_rst)
   );

   scsi_si_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_addr  (reg_addr),
      .wr_data  (reg_wdata),
      .load     (dma_load),
      .clear    (evt_dma_done),
      .live     (live),
      .eff_len  (xfer_len),
      .lane_hit (lane_hit)
   );

   scsi_si_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .dma_done  (evt_dma_done),
      .cmd_done  (evt_cmd_done),
      .phase     (bus_phase),
      .disc      (sel_fail || evt_sel_timeout),
      .bus_rst   (bus_rst),
      .rst_mask  (mask_q),
      .par_err   (evt_parity_err),
      .gross_err (evt_gross_err),
      .why_rd    (why_rd),
      .tc_clr    (lane_hit),
      .status    (status),
      .why       (why),
      .step      (step),
      .irq       (irq)
   );

   logic [CNT_W-1:0] live_sh;
   assign live_sh = live >> {reg_addr, 3'b000};

   always_comb begin
      if (reg_addr < 6'(LANES))
         reg_rdata = live_sh[7:0];
      else begin
         unique case (reg_addr)
            ADR_STAT: reg_rdata = status;
            ADR_WHY:  reg_rdata = why;
            ADR_STEP: reg_rdata = step;
            ADR_ID:   reg_rdata = CHIP_ID;
            default:  reg_rdata = '0;
         endcase
      end
   end

   p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_len != '0);
   p_disc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_fail && !evt_dma_done && !evt_cmd_done) |=> (irq && why == WHY_DC && step == '0));
endmodule

// File: tb/scsi_stat_irq_test.sv
module scsi_stat_irq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [6:0]  tgt_present = '0;
   logic [2:0]  bus_phase = '0;
   logic        evt_dma_done = 0, evt_sel_timeout = 0, evt_cmd_done = 0;
   logic        evt_parity_err = 0, evt_gross_err = 0;
   logic        irq;
   logic [16:0] xfer_len;

   always #5 clk = ~clk;

   scsi_stat_irq uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tgt_present(tgt_present), .bus_phase(bus_phase),
      .evt_dma_done(evt_dma_done), .evt_sel_timeout(evt_sel_timeout),
      .evt_cmd_done(evt_cmd_done), .evt_parity_err(evt_parity_err),
      .evt_gross_err(evt_gross_err), .irq(irq), .xfer_len(xfer_len)
   );

   // scoreboard: kind 0 = read data, 1 = irq, 2 = xfer_len
   int    q_kind[$];
   int    q_exp[$];
   string q_req[$];
   int    n_chk = 0, n_fail = 0;
   bit    finished = 0;

   task automatic push(input int kind, input int exp, input string req);
      q_kind.push_back(kind);
      q_exp.push_back(exp);
      q_req.push_back(req);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         #4;
         while (q_kind.size() > 0) begin
            int k, e, a;
            string r;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            r = q_req.pop_front();
            a = (k == 0) ? int'(reg_rdata) : (k == 1) ? int'(irq) : int'(xfer_len);
            n_chk++;
            if (a != e) begin
               n_fail++;
               $display("FAIL %s: kind %0d actual 0x%0h expected 0x%0h", r, k, a, e);
            end
         end
      end
   end

   task automatic end_step();
      @(posedge clk);
      #1;
      reg_wr = 0; reg_rd = 0;
      evt_dma_done = 0; evt_sel_timeout = 0; evt_cmd_done = 0;
      evt_parity_err = 0; evt_gross_err = 0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      end_step();
   endtask

   // ev bits: 0 dma_done, 1 sel_timeout, 2 cmd_done, 3 parity, 4 gross
   task automatic rd_ev(input logic [5:0] a, input int exp, input string req, input logic [4:0] ev);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      {evt_gross_err, evt_parity_err, evt_cmd_done, evt_sel_timeout, evt_dma_done} = ev;
      push(0, exp, req);
      end_step();
   endtask

   task automatic rd(input logic [5:0] a, input int exp, input string req);
      rd_ev(a, exp, req, 5'b0);
   endtask

   task automatic ev(input logic [4:0] m);
      @(negedge clk);
      {evt_gross_err, evt_parity_err, evt_cmd_done, evt_sel_timeout, evt_dma_done} = m;
      end_step();
   endtask

   task automatic chk(input int kind, input int exp, input string req);
      @(negedge clk);
      push(kind, exp, req);
      end_step();
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(6'h04, 0, "R1"); rd(6'h05, 0, "R1"); rd(6'h06, 0, "R1");
      rd(6'h00, 0, "R1"); rd(6'h01, 0, "R1"); rd(6'h0E, 4, "R1");
      chk(1, 0, "R1");
      chk(2, 17'h10000, "R2");
      // R3 shadow writes
      wr(6'h00, 8'h34); wr(6'h01, 8'h12);
      rd(6'h00, 0, "R3"); rd(6'h01, 0, "R3");
      chk(2, 17'h10000, "R3");
      // R4 DMA command loads
      wr(6'h03, 8'h90);
      rd(6'h00, 8'h34, "R4"); rd(6'h01, 8'h12, "R4");
      chk(2, 16'h1234, "R2");
      wr(6'h00, 8'h01); wr(6'h03, 8'h00);
      rd(6'h00, 8'h34, "R4");
      // R6 DMA done
      ev(5'b00001);
      chk(1, 1, "R6");
      rd(6'h04, 8'h90, "R6"); rd(6'h06, 0, "R6"); rd(6'h00, 0, "R6");
      chk(2, 17'h10000, "R6");
      // R7 reading reason clears
      rd(6'h05, 8'h10, "R7");
      chk(1, 0, "R7");
      rd(6'h04, 8'h10, "R7");
      rd(6'h05, 8'h10, "R7");
      // R5 counter write clears TC
      wr(6'h01, 8'h00);
      rd(6'h04, 8'h00, "R5");
      // R11 error bits
      ev(5'b11000);
      chk(1, 0, "R11");
      rd(6'h04, 8'h60, "R11");
      rd(6'h05, 8'h10, "R7");
      rd(6'h04, 8'h00, "R7");
      // R8 command done
      bus_phase = 3'd3;
      ev(5'b00100);
      chk(1, 1, "R8");
      rd(6'h04, 8'h93, "R8");
      rd(6'h06, 4, "R8");
      rd(6'h05, 8'h18, "R8");
      rd(6'h04, 8'h13, "R8");
      chk(1, 0, "R8");
      // R9 absent target
      tgt_present = 7'b0000100;
      wr(6'h04, 8'h05); wr(6'h03, 8'h42);
      chk(1, 1, "R9");
      rd(6'h04, 8'h80, "R9"); rd(6'h06, 0, "R9"); rd(6'h05, 8'h20, "R9");
      // R9 present target: nothing changes
      ev(5'b00100);
      rd(6'h05, 8'h18, "R8");
      wr(6'h04, 8'h02); wr(6'h03, 8'h42);
      chk(1, 0, "R9");
      rd(6'h04, 8'h13, "R9"); rd(6'h06, 4, "R9"); rd(6'h05, 8'h18, "R9");
      // R9 host id 7 with DMA bit, shadow is 0x0001
      tgt_present = 7'h7F;
      wr(6'h04, 8'h07); wr(6'h03, 8'hC1);
      chk(1, 1, "R9");
      rd(6'h04, 8'h80, "R9"); rd(6'h00, 8'h01, "R4"); rd(6'h05, 8'h20, "R9");
      // R9 selection timeout
      ev(5'b00010);
      chk(1, 1, "R9");
      rd(6'h04, 8'h80, "R9"); rd(6'h05, 8'h20, "R9");
      // R10 bus reset masked then unmasked
      wr(6'h08, 8'h40); wr(6'h03, 8'h03);
      chk(1, 0, "R10");
      rd(6'h05, 8'h80, "R10");
      wr(6'h08, 8'h00); wr(6'h03, 8'h03);
      chk(1, 1, "R10");
      rd(6'h05, 8'h80, "R10");
      chk(1, 0, "R10");
      // R12 event beats clear-on-read
      ev(5'b00001);
      rd_ev(6'h05, 8'h10, "R12", 5'b00001);
      chk(1, 1, "R12");
      rd(6'h04, 8'h90, "R12");
      rd(6'h05, 8'h10, "R7");
      // R2 zero and full counts
      wr(6'h00, 8'h00); wr(6'h03, 8'h80);
      chk(2, 17'h10000, "R2");
      wr(6'h00, 8'hFF); wr(6'h01, 8'hFF); wr(6'h03, 8'h80);
      chk(2, 17'hFFFF, "R2");
      rd(6'h01, 8'hFF, "R3");
      repeat (2) @(negedge clk);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule